// File: doc/BRIEF.md
# Triggered Linear Frequency Sweep Controller

This block drives a phase-accumulator tone generator through a linear frequency sweep. Software loads the sweep parameters through a 12-bit register write port: a start tuning word, a per-step frequency increment, a segment count, an increment interval, a burst interval and a mode bit. A pulse on the trigger input starts the sweep. Each segment runs at the frequency `start + k*step`. A 24-bit phase accumulator advances by the current tuning word once per clock, and its upper 10 bits go to a downstream waveform lookup table. Phase zero is taken to map to midscale.

The block has two modes. In continuous mode the segments follow each other directly. In burst mode each segment plays its tone for the burst interval and then holds the phase at zero for the increment interval, which gives a quiet listening window before the next frequency. In both modes the accumulator restarts from zero at the start of every segment, so the phase at each step boundary is always known. After the last segment the block holds the final frequency, raises a done flag and waits for another trigger. A write to the control register is the soft reset: it returns the block to a quiet idle state.

Top module: `fsweep_ctrl`

## Requirements
- R1: After rst_ni is released, tuning_o, phase_acc_o and phase_o are zero and active_o and done_o are low.
- R2: The register addresses are 0 control, 1 segment count, 2 step low half, 3 step high half, 4 increment interval, 5 burst interval, 6 start low half and 7 start high half. Each 24-bit word is {high half, low half}, and bit 7 of the control word selects burst mode when it is 1.
- R3: Segment k (k = 0 to N-1) uses the tuning word start + k*step, taken modulo 2^24. A sweep has N segments, where N is the programmed count and a count of 0 is treated as 1.
- R4: In continuous mode each segment lasts Ti cycles. During a segment, phase_acc_o reads 0 in its first cycle and then adds tuning_o on every clock. active_o is high throughout the sweep.
- R5: In burst mode each segment plays the tone for Tb cycles, in the same way as R4. phase_acc_o then stays at 0 for Ti cycles before the next segment starts. active_o stays high during this listening window.
- R6: phase_o always equals bits 23..14 of phase_acc_o.
- R7: After the last segment, done_o goes high, active_o goes low and tuning_o holds the final word. The accumulator keeps running at that word. In continuous mode it runs on from the last segment. In burst mode it starts from 0 after the last listening window.
- R8: A trigger is sampled on a clock edge, and the first segment is visible in the cycle after that edge. A trigger is accepted in idle or done and starts a new sweep. A trigger is ignored while a sweep is active.
- R9: A control register write sends the block to idle on the next edge, from any state. In idle, tuning_o and phase_acc_o are zero and both status flags are low until a trigger arrives. A control write takes priority over a trigger in the same cycle.
- R10: Ti and Tb count clock cycles, and a programmed value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 12 | Register write data |
| trig_i | input | 1 | Sweep start trigger |
| tuning_o | output | 24 | Current tuning word |
| phase_acc_o | output | 24 | Phase accumulator |
| phase_o | output | 10 | Truncated phase to the waveform lookup |
| active_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished, final frequency held |

## Verification
The bench compares every cycle of each sweep against a closed-form model. It covers segment boundaries, the burst tone-to-listen switch and the hand-off into done. A design that failed to clear the accumulator at a step, or that was off by one in its interval count, would show a shifted phase ramp. Zero-valued counts and intervals are tested because a design that did not clamp them would stall or wrap for 4096 cycles. A start word near the top of the range checks that the step addition wraps modulo 2^24. Triggers are applied mid-sweep, where they must be ignored, and in done, where they must restart the sweep. A control write is applied mid-sweep, and a design that failed to reset from every state would keep sweeping.

// File: rtl/fsweep_pkg.sv
package fsweep_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_LISTEN, ST_DONE} sweep_st_e;

  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned BURST_BIT = 7;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_STEP_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_STEP_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_T_INC   = 3'd4;
  localparam logic [ADDR_W-1:0] A_T_BURST = 3'd5;
  localparam logic [ADDR_W-1:0] A_START_LO = 3'd6;
  localparam logic [ADDR_W-1:0] A_START_HI = 3'd7;
endpackage

// File: rtl/fsweep_regs.sv
module fsweep_regs
  import fsweep_pkg::*;
#(
  parameter int unsigned FREQ_W = 24,
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              ctrl_wr_o,
  output logic              burst_o,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] t_inc_o,
  output logic [DATA_W-1:0] t_burst_o,
  output logic [FREQ_W-1:0] start_o,
  output logic [FREQ_W-1:0] step_o
);
  localparam int unsigned HALF_W = FREQ_W / 2;

  logic [HALF_W-1:0] start_lo_q, start_hi_q, step_lo_q, step_hi_q;

  assign ctrl_wr_o = wr_en_i && (wr_addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_o    <= 1'b0;
      count_o    <= '0;
      t_inc_o    <= '0;
      t_burst_o  <= '0;
      start_lo_q <= '0;
      start_hi_q <= '0;
      step_lo_q  <= '0;
      step_hi_q  <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_CTRL:     burst_o    <= wr_data_i[BURST_BIT];
        A_COUNT:    count_o    <= wr_data_i;
        A_STEP_LO:  step_lo_q  <= wr_data_i[HALF_W-1:0];
        A_STEP_HI:  step_hi_q  <= wr_data_i[HALF_W-1:0];
        A_T_INC:    t_inc_o    <= wr_data_i;
        A_T_BURST:  t_burst_o  <= wr_data_i;
        A_START_LO: start_lo_q <= wr_data_i[HALF_W-1:0];
        default:    start_hi_q <= wr_data_i[HALF_W-1:0];
      endcase
    end
  end

  assign start_o = {start_hi_q, start_lo_q};
  assign step_o  = {step_hi_q, step_lo_q};
endmodule

// File: rtl/fsweep_seq.sv
module fsweep_seq
  import fsweep_pkg::*;
#(
  parameter int unsigned FREQ_W = 24,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              trig_i,
  input  logic              burst_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  t_inc_i,
  input  logic [CNT_W-1:0]  t_burst_i,
  input  logic [FREQ_W-1:0] start_i,
  input  logic [FREQ_W-1:0] step_i,
  output logic [FREQ_W-1:0] tuning_o,
  output logic              acc_clr_o,
  output sweep_st_e         state_o
);
  sweep_st_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, seg_q, seg_d;
  logic [CNT_W-1:0]  n_eff, ti_eff, tb_eff, limit;
  logic [FREQ_W-1:0] tune_q, tune_d;
  logic              seg_end, last_seg, trig_go, adv;

  always_comb begin
    n_eff  = (count_i   == '0) ? CNT_W'(1) : count_i;
    ti_eff = (t_inc_i   == '0) ? CNT_W'(1) : t_inc_i;
    tb_eff = (t_burst_i == '0) ? CNT_W'(1) : t_burst_i;
    limit    = (state_q == ST_RUN && burst_i) ? tb_eff : ti_eff;
    seg_end  = (cnt_q == limit - CNT_W'(1));
    last_seg = (seg_q == n_eff - CNT_W'(1));
    trig_go  = trig_i && (state_q == ST_IDLE || state_q == ST_DONE);

    state_d   = state_q;
    cnt_d     = cnt_q + CNT_W'(1);
    seg_d     = seg_q;
    tune_d    = tune_q;
    acc_clr_o = 1'b1;
    adv       = 1'b0;

    unique case (state_q)
      ST_IDLE: cnt_d = '0;
      ST_RUN: begin
        acc_clr_o = 1'b0;
        if (seg_end) begin
          cnt_d = '0;
          if (burst_i) begin
            state_d   = ST_LISTEN;
            acc_clr_o = 1'b1;
          end else if (last_seg) begin
            state_d = ST_DONE;        // keep accumulating
          end else begin
            adv       = 1'b1;
            acc_clr_o = 1'b1;
          end
        end
      end
      ST_LISTEN: begin
        if (seg_end) begin
          cnt_d = '0;
          if (last_seg) state_d = ST_DONE;
          else begin
            adv     = 1'b1;
            state_d = ST_RUN;
          end
        end
      end
      default: begin
        cnt_d     = '0;
        acc_clr_o = 1'b0;
      end
    endcase

    if (adv) begin
      seg_d  = seg_q + CNT_W'(1);
      tune_d = tune_q + step_i;
    end
    if (trig_go) begin
      state_d   = ST_RUN;
      cnt_d     = '0;
      seg_d     = '0;
      tune_d    = start_i;
      acc_clr_o = 1'b1;
    end
    if (ctrl_wr_i) begin
      state_d   = ST_IDLE;
      cnt_d     = '0;
      seg_d     = '0;
      tune_d    = '0;
      acc_clr_o = 1'b1;
      adv       = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      seg_q   <= '0;
      tune_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      seg_q   <= seg_d;
      tune_q  <= tune_d;
    end
  end

  assign tuning_o = tune_q;
  assign state_o  = state_q;

  // R3
  tuning_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> tune_q == $past(tune_q + step_i));

  // R9
  ctrl_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (state_q == ST_IDLE && tune_q == '0));

  // R10
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN || state_q == ST_LISTEN) |-> cnt_q < limit);
endmodule

// File: rtl/fsweep_phase.sv
module fsweep_phase #(
  parameter int unsigned FREQ_W  = 24,
  parameter int unsigned PHASE_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [FREQ_W-1:0]  tune_i,
  output logic [FREQ_W-1:0]  acc_o,
  output logic [PHASE_W-1:0] phase_o
);
  localparam int unsigned LSB = FREQ_W - PHASE_W;

  logic [FREQ_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= acc_q + tune_i;
  end

  assign acc_o   = acc_q;
  assign phase_o = acc_q[FREQ_W-1:LSB];
endmodule

// File: rtl/fsweep_ctrl.sv
module fsweep_ctrl
  import fsweep_pkg::*;
#(
  parameter int unsigned FREQ_W  = 24,
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned PHASE_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               trig_i,
  output logic [FREQ_W-1:0]  tuning_o,
  output logic [FREQ_W-1:0]  phase_acc_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               active_o,
  output logic               done_o
);
  logic              ctrl_wr, burst, acc_clr;
  logic [DATA_W-1:0] count, t_inc, t_burst;
  logic [FREQ_W-1:0] start, step;
  sweep_st_e         state;

  fsweep_regs #(.FREQ_W(FREQ_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_wr_o(ctrl_wr), .burst_o(burst), .count_o(count),
    .t_inc_o(t_inc), .t_burst_o(t_burst), .start_o(start), .step_o(step)
  );

  fsweep_seq #(.FREQ_W(FREQ_W), .CNT_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .ctrl_wr_i(ctrl_wr), .trig_i, .burst_i(burst),
    .count_i(count), .t_inc_i(t_inc), .t_burst_i(t_burst),
    .start_i(start), .step_i(step), .tuning_o,
    .acc_clr_o(acc_clr), .state_o(state)
  );

  fsweep_phase #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_phase (
    .clk_i, .rst_ni, .clr_i(acc_clr), .tune_i(tuning_o),
    .acc_o(phase_acc_o), .phase_o
  );

  assign active_o = (state == ST_RUN) || (state == ST_LISTEN);
  assign done_o   = (state == ST_DONE);

  // R5
  listen_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_LISTEN |-> phase_acc_o == '0);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> (phase_acc_o == '0 && tuning_o == '0));

  // R7
  status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_o && done_o));

  // R4
  seg_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RUN && $changed(tuning_o)) |-> phase_acc_o == '0);
endmodule

// File: tb/fsweep_ctrl_tb.sv
module fsweep_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [11:0] wr_data_i = '0;
  logic        trig_i = 1'b0;
  logic [23:0] tuning_o, phase_acc_o;
  logic [9:0]  phase_o;
  logic        active_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit          m_burst;
  int          m_n, m_ti, m_tb;
  logic [23:0] m_start, m_step;

  fsweep_ctrl u_dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // R2 address map and halves
  task automatic prog(input bit b, input int n, input int ti, input int tb,
                      input logic [23:0] st, input logic [23:0] sp);
    m_burst = b; m_n = n; m_ti = ti; m_tb = tb; m_start = st; m_step = sp;
    wr(3'd1, 12'(n));
    wr(3'd2, sp[11:0]);
    wr(3'd3, sp[23:12]);
    wr(3'd4, 12'(ti));
    wr(3'd5, 12'(tb));
    wr(3'd6, st[11:0]);
    wr(3'd7, st[23:12]);
    wr(3'd0, b ? 12'h080 : 12'h37F);
  endtask

  task automatic model(input int c, output logic [23:0] tw, output logic [23:0] acc,
                       output bit act, output bit dn);
    int t, b, n, p, seg, off;
    t = (m_ti == 0) ? 1 : m_ti;
    b = (m_tb == 0) ? 1 : m_tb;
    n = (m_n == 0) ? 1 : m_n;
    p = m_burst ? b + t : t;
    if (c < n * p) begin
      seg = c / p; off = c % p;
      tw  = 24'(m_start + 24'(seg) * m_step);
      acc = (m_burst && off >= b) ? 24'd0 : 24'(24'(off) * tw);
      act = 1'b1; dn = 1'b0;
    end else begin
      tw  = 24'(m_start + 24'(n - 1) * m_step);
      acc = m_burst ? 24'(24'(c - n * p) * tw) : 24'(24'(c - (n - 1) * p) * tw);
      act = 1'b0; dn = 1'b1;
    end
  endtask

  function automatic int sweep_len();
    int t, b, n;
    t = (m_ti == 0) ? 1 : m_ti;
    b = (m_tb == 0) ? 1 : m_tb;
    n = (m_n == 0) ? 1 : m_n;
    return n * (m_burst ? b + t : t);
  endfunction

  // R8 trigger, R3/R4/R5/R6/R7/R10 per cycle
  task automatic sweep(input int extra, input bit mid_trig);
    logic [23:0] tw, acc;
    bit act, dn;
    int len;
    len = sweep_len();
    @(negedge clk_i); trig_i = 1'b1;
    @(negedge clk_i); trig_i = 1'b0;
    for (int c = 0; c < len + extra; c++) begin
      model(c, tw, acc, act, dn);
      chk(tuning_o == tw, "R3", "tuning", 32'(tuning_o), 32'(tw));
      chk(phase_acc_o == acc, m_burst ? "R5" : "R4", "acc", 32'(phase_acc_o), 32'(acc));
      chk(phase_o == acc[23:14], "R6", "phase", 32'(phase_o), 32'(acc[23:14]));
      chk(active_o == act && done_o == dn, "R7", "status",
          {30'd0, active_o, done_o}, {30'd0, act, dn});
      trig_i = (mid_trig && c == 1 && len >= 2);  // R8 must be ignored
      @(negedge clk_i);
    end
    trig_i = 1'b0;
  endtask

  task automatic chk_idle(input string req);
    chk(tuning_o == 0 && phase_acc_o == 0 && phase_o == 0, req, "idle outputs",
        32'(phase_acc_o), 32'd0);
    chk(!active_o && !done_o, req, "idle status", {30'd0, active_o, done_o}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1");

    // R2/R4 continuous directed
    prog(1'b0, 3, 4, 2, 24'h123456, 24'h010000);
    repeat (3) @(negedge clk_i);
    chk_idle("R9");  // idle holds without trigger
    sweep(5, 1'b0);
    // R8 retrigger from done
    sweep(3, 1'b0);

    // R5 burst directed
    prog(1'b1, 3, 3, 2, 24'h000800, 24'h000400);
    sweep(4, 1'b1);

    // R10 zero intervals and count
    prog(1'b0, 0, 0, 0, 24'h0ABCDE, 24'h111111);
    sweep(4, 1'b0);
    prog(1'b1, 2, 0, 0, 24'h400000, 24'h100000);
    sweep(4, 1'b1);

    // R3 wraparound
    prog(1'b0, 4, 2, 1, 24'hFFFFF0, 24'h000020);
    sweep(3, 1'b1);

    // R9 control write mid-sweep, priority over trigger
    prog(1'b1, 5, 6, 4, 24'h200000, 24'h010101);
    @(negedge clk_i); trig_i = 1'b1;
    @(negedge clk_i); trig_i = 1'b0;
    repeat (3) @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 12'h080; trig_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; trig_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk_idle("R9");
      @(negedge clk_i);
    end
    sweep(3, 1'b0);

    // random sweeps
    for (int k = 0; k < 30; k++) begin
      prog(1'($urandom_range(0, 1)), $urandom_range(0, 5), $urandom_range(0, 6),
           $urandom_range(0, 5), 24'($urandom), 24'($urandom));
      sweep($urandom_range(1, 5), 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule